// File: doc/BRIEF.md
# Throttled Round-Robin Bus Arbiter with Channel Table

This block decides which bus master may drive a shared system bus. Arbitration is done over sixteen request/grant channels, not over the masters directly. A small configuration table gives each channel three settings: an enable bit, the index of the master that owns it, and a two-bit throttle code. A master that needs more bandwidth is given several channels. Each clock, every master request line is routed through the table into a registered per-channel request bit. A channel that is disabled, or whose owner is not requesting, leaves its bit clear.

A two-state controller does the arbitration. In IDLE it evaluates the registered requests on every clock. Each channel keeps a phase counter, and a throttled channel takes part only in some of its arbitration rounds. The winner is chosen by round-robin, starting from the channel after the one last granted. The controller then moves to HOLD. It keeps the one-hot channel grant and the one-hot grant to the owning master until the bus reports that the transfer is done. It then returns to IDLE and arbitrates again on the next clock.

State transitions:
- IDLE→HOLD when an eligible channel exists.
- IDLE→IDLE when none exists.
- HOLD→IDLE when the transfer-done input is high.
- HOLD→HOLD otherwise.

Top module: `bus_channel_arbiter`

## Requirements
- R1: After reset no grant is active. Only channel 0 is enabled; it is owned by master 0 with throttle code 00. Requests from masters 1..15 therefore produce no grant until the table is written.
- R2: On each clock, channel c's request bit is registered as (enable of c) AND (the request line of c's owner master). A disabled channel is never granted, whatever the request lines do.
- R3: When the controller is idle and a request line rises on an enabled, unthrottled channel, the grant appears on the second rising clock edge after the line is seen high.
- R4: At most one bit of `ch_gnt` is set. `mst_gnt` is one-hot exactly when `ch_gnt` is non-zero. `mst_gnt` names the owner master that was recorded when the grant was issued.
- R5: A grant stays unchanged while `xfer_done` is low. If `xfer_done` is high on an edge during a grant, both grant outputs clear on that edge. Arbitration then resumes on the next edge.
- R6: Among eligible channels, the winner is the first one found when scanning upward (with wrap-around) from the channel after the last one granted. After reset the scan starts at channel 0.
- R7: Each channel has a 2-bit phase. The phase advances by one (modulo 4) on every idle clock on which that channel's request bit is set. The channel is eligible only when phase >= code. Code 00 gives 100% participation, 01 gives 75%, 10 gives 50% and 11 gives 25%.
- R8: A table write uses `cfg_we`, the channel number on `cfg_addr`, and `cfg_wdata` laid out as: bit 6 = enable, bits 5:2 = owner master, bits 1:0 = throttle code. It takes effect from the next clock and clears that channel's phase to 0.
- R9: Several channels may share one owner. Each of them is arbitrated separately, and every grant on any of them raises the same `mst_gnt` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mst_req | input | 16 | Request line of each bus master |
| xfer_done | input | 1 | High when the current bus transfer completes |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 4 | Channel selected for the write |
| cfg_wdata | input | 7 | Write data: enable, owner master, throttle code |
| ch_gnt | output | 16 | One-hot channel grant |
| mst_gnt | output | 16 | One-hot grant to the owning master |

## Verification
The hardest situation to reach from the ports is a throttled channel being skipped while other channels compete. Its phase only moves on idle clocks when its request bit is set, so the skip pattern depends on the whole history of requests, grants and table writes. The stimulus first runs a lone 25% channel with the transfer completing every cycle, where the grant rate can be predicted exactly. It then mixes throttle codes across channels that share one master. Finally it runs a long random phase in which requests, completions and table writes (which reset phases) all interleave. A behavioural model follows every phase counter and is compared on each clock.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_e;

    // throttle codes (participation share)
    localparam logic [1:0] THR_FULL    = 2'b00;
    localparam logic [1:0] THR_QUARTER = 2'b11;

endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs #(
    parameter int NUM_CH   = 16,
    parameter int NUM_MST  = 16,
    parameter int BOOT_CH  = 0,
    parameter int BOOT_MST = 0,
    localparam int CW = $clog2(NUM_CH),
    localparam int MW = $clog2(NUM_MST),
    localparam int DW = MW + 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [CW-1:0]                addr,
    input  logic [DW-1:0]                wdata,
    output logic [NUM_CH-1:0]            en_vec,
    output logic [NUM_CH-1:0][MW-1:0]    own_idx,
    output logic [NUM_CH-1:0][1:0]       thr_code,
    output logic [NUM_CH-1:0]            wr_hit
);
    import arb_pkg::*;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_entry
        localparam logic          RST_EN  = (c == BOOT_CH);
        localparam logic [MW-1:0] RST_OWN = (c == BOOT_CH) ? MW'(BOOT_MST) : '0;

        assign wr_hit[c] = we && (addr == CW'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_vec[c]   <= RST_EN;
                own_idx[c]  <= RST_OWN;
                thr_code[c] <= THR_FULL;
            end else if (wr_hit[c]) begin
                en_vec[c]   <= wdata[DW-1];
                own_idx[c]  <= wdata[MW+1:2];
                thr_code[c] <= wdata[1:0];
            end
        end
    end

endmodule

// File: rtl/arb_req_gate.sv
module arb_req_gate #(
    parameter int NUM_CH  = 16,
    parameter int NUM_MST = 16,
    localparam int MW = $clog2(NUM_MST)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_MST-1:0]           mst_req,
    input  logic [NUM_CH-1:0]            en_vec,
    input  logic [NUM_CH-1:0][MW-1:0]    own_idx,
    input  logic [NUM_CH-1:0][1:0]       thr_code,
    input  logic [NUM_CH-1:0]            wr_hit,
    input  logic                         round,
    output logic [NUM_CH-1:0]            req_q,
    output logic [NUM_CH-1:0]            eligible
);
    import arb_pkg::*;

    logic [NUM_CH-1:0][1:0] phase;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        // gated request register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q[c] <= 1'b0;
            else        req_q[c] <= en_vec[c] && mst_req[own_idx[c]];
        end

        // throttle phase: advances on idle rounds with a pending request
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  phase[c] <= 2'b00;
            else if (wr_hit[c])          phase[c] <= 2'b00;
            else if (round && req_q[c])  phase[c] <= phase[c] + 2'b01;
        end

        assign eligible[c] = req_q[c] && (phase[c] >= thr_code[c]);

        // R7: a 25% channel cannot compete in two consecutive rounds
        a_r7_quarter_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (round && eligible[c] && thr_code[c] == THR_QUARTER && !wr_hit[c]) |=> !eligible[c]);
    end

    // R2: a request bit is only set for a channel enabled one clock earlier
    a_r2_gated_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q & ~$past(en_vec)) == '0);

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int NUM_CH = 16,
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] eligible,
    input  logic [CW-1:0]     last,
    output logic              found,
    output logic [CW-1:0]     win
);

    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = 1; i <= NUM_CH; i++) begin
            int idx;
            idx = (int'(last) + i) % NUM_CH;
            if (!found && eligible[idx]) begin
                found = 1'b1;
                win   = CW'(idx);
            end
        end
    end

endmodule

// File: rtl/bus_channel_arbiter.sv
module bus_channel_arbiter #(
    parameter int NUM_CH   = 16,
    parameter int NUM_MST  = 16,
    parameter int BOOT_CH  = 0,
    parameter int BOOT_MST = 0,
    localparam int CW = $clog2(NUM_CH),
    localparam int MW = $clog2(NUM_MST),
    localparam int DW = MW + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] mst_req,
    input  logic               xfer_done,
    input  logic               cfg_we,
    input  logic [CW-1:0]      cfg_addr,
    input  logic [DW-1:0]      cfg_wdata,
    output logic [NUM_CH-1:0]  ch_gnt,
    output logic [NUM_MST-1:0] mst_gnt
);
    import arb_pkg::*;

    arb_state_e               state, state_nxt;
    logic [NUM_CH-1:0]        en_vec, wr_hit, req_q, eligible;
    logic [NUM_CH-1:0][MW-1:0] own_idx;
    logic [NUM_CH-1:0][1:0]   thr_code;
    logic [CW-1:0]            last_q, win;
    logic                     found, round;

    assign round = (state == ST_IDLE);

    arb_cfg_regs #(
        .NUM_CH(NUM_CH), .NUM_MST(NUM_MST), .BOOT_CH(BOOT_CH), .BOOT_MST(BOOT_MST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .en_vec(en_vec), .own_idx(own_idx), .thr_code(thr_code), .wr_hit(wr_hit)
    );

    arb_req_gate #(
        .NUM_CH(NUM_CH), .NUM_MST(NUM_MST)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .en_vec(en_vec),
        .own_idx(own_idx), .thr_code(thr_code), .wr_hit(wr_hit), .round(round),
        .req_q(req_q), .eligible(eligible)
    );

    arb_rr_pick #(
        .NUM_CH(NUM_CH)
    ) u_pick (
        .eligible(eligible), .last(last_q), .found(found), .win(win)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (found)     state_nxt = ST_HOLD;
            ST_HOLD: if (xfer_done) state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // registered grant outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_gnt  <= '0;
            mst_gnt <= '0;
            last_q  <= CW'(NUM_CH - 1);
        end else begin
            unique case (state)
                ST_IDLE: if (found) begin
                    ch_gnt  <= NUM_CH'(1) << win;
                    mst_gnt <= NUM_MST'(1) << own_idx[win];
                    last_q  <= win;
                end
                ST_HOLD: if (xfer_done) begin
                    ch_gnt  <= '0;
                    mst_gnt <= '0;
                end
            endcase
        end
    end

    // R4: single channel grant, single master grant, both present together
    a_r4_one_channel: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ch_gnt));
    a_r4_one_master:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mst_gnt));
    a_r4_paired:      assert property (@(posedge clk) disable iff (!rst_n)
        (ch_gnt != '0) == (mst_gnt != '0));
    // R5: grant held until done, then dropped
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_gnt != '0 && !xfer_done) |=> $stable(ch_gnt) && $stable(mst_gnt));
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_gnt != '0 && xfer_done) |=> ch_gnt == '0);
    // R6: no grant appears without an eligible channel
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_gnt == '0 && eligible == '0) |=> ch_gnt == '0);

endmodule

// File: tb/bus_channel_arbiter_test.sv
module bus_channel_arbiter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int NM  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mst_req = '0;
    logic        xfer_done = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [6:0]  cfg_wdata = '0;
    logic [15:0] ch_gnt, mst_gnt;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done_flag = 0;

    bus_channel_arbiter uut (
        .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .xfer_done(xfer_done),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ch_gnt(ch_gnt), .mst_gnt(mst_gnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_en[NCH], m_own[NCH], m_code[NCH], m_ph[NCH], m_req[NCH];
    int m_busy, m_gnt, m_last, m_gown;

    always @(posedge clk) begin
        int w;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_en[c] = (c == 0); m_own[c] = 0; m_code[c] = 0; m_ph[c] = 0; m_req[c] = 0;
            end
            m_busy = 0; m_gnt = 0; m_last = NCH - 1; m_gown = 0;
        end else begin
            if (m_busy != 0) begin
                if (xfer_done) m_busy = 0;
            end else begin
                w = -1;
                for (int i = 1; i <= NCH; i++) begin
                    int c;
                    c = (m_last + i) % NCH;
                    if (w < 0 && m_req[c] != 0 && m_ph[c] >= m_code[c]) w = c;
                end
                for (int c = 0; c < NCH; c++) if (m_req[c] != 0) m_ph[c] = (m_ph[c] + 1) % 4;
                if (w >= 0) begin m_busy = 1; m_gnt = w; m_last = w; m_gown = m_own[w]; end
            end
            for (int c = 0; c < NCH; c++) m_req[c] = (m_en[c] != 0 && mst_req[m_own[c]]) ? 1 : 0;
            if (cfg_we) begin
                m_en[cfg_addr] = cfg_wdata[6]; m_own[cfg_addr] = cfg_wdata[5:2];
                m_code[cfg_addr] = cfg_wdata[1:0]; m_ph[cfg_addr] = 0;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        logic [15:0] e_ch, e_m;
        if (rst_n && !done_flag) begin
            e_ch = (m_busy != 0) ? (16'(1) << m_gnt) : 16'h0;
            e_m  = (m_busy != 0) ? (16'(1) << m_gown) : 16'h0;
            n_cmp++;
            if (ch_gnt !== e_ch) begin
                n_bad++; $display("FAIL R5/R6 ch_gnt cyc %0d act %h exp %h", cyc, ch_gnt, e_ch);
            end
            n_cmp++;
            if (mst_gnt !== e_m) begin
                n_bad++; $display("FAIL R4 mst_gnt cyc %0d act %h exp %h", cyc, mst_gnt, e_m);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++; $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int ch, input bit en, input int own, input int code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(ch); cfg_wdata = {en, 4'(own), 2'(code)};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done_flag) begin
            n_bad++; $display("FAIL watchdog expired act %0d exp <100000", cyc);
            finish_run();
        end
    end

    int cnt[NCH];

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and no grant for non-boot masters
        chk("R1 reset ch_gnt", ch_gnt, 16'h0);
        chk("R1 reset mst_gnt", mst_gnt, 16'h0);
        mst_req = 16'hFFFE;
        repeat (6) begin @(negedge clk); chk("R1 only boot channel", ch_gnt, 16'h0); end
        mst_req = 16'h0;
        repeat (2) @(negedge clk);

        // R3: latency of two edges; R5: hold and release
        mst_req = 16'h0001;
        @(negedge clk); chk("R3 not yet granted", ch_gnt, 16'h0);
        @(negedge clk); chk("R3 grant ch0", ch_gnt, 16'h0001);
        chk("R4 owner master 0", mst_gnt, 16'h0001);
        repeat (3) begin @(negedge clk); chk("R5 held without done", ch_gnt, 16'h0001); end
        xfer_done = 1'b1;
        @(negedge clk); chk("R5 released on done", ch_gnt, 16'h0);
        xfer_done = 1'b0;
        @(negedge clk); chk("R5 re-arbitrate next clock", ch_gnt, 16'h0001);
        mst_req = 16'h0; xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        repeat (2) @(negedge clk);

        // R2/R8: disabled entry blocks master 5
        cfg_write(6, 1'b0, 5, 0);
        mst_req = 16'h0020;
        repeat (8) begin @(negedge clk); chk("R2 disabled channel", ch_gnt, 16'h0); end
        cfg_write(6, 1'b1, 5, 0);
        repeat (2) @(negedge clk);
        chk("R8 write enables ch6", ch_gnt, 16'h0040);
        chk("R8 owner field master 5", mst_gnt, 16'h0020);

        // R6/R9: three channels for master 5
        cfg_write(3, 1'b1, 5, 0);
        cfg_write(7, 1'b1, 5, 0);
        xfer_done = 1'b1;
        for (int c = 0; c < NCH; c++) cnt[c] = 0;
        repeat (30) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) if (ch_gnt[c]) cnt[c]++;
            if (ch_gnt != 0) chk("R9 shared owner grant", mst_gnt, 16'h0020);
        end
        chk("R6 rr share ch3", 16'(cnt[3] >= 4), 16'h1);
        chk("R6 rr share ch6", 16'(cnt[6] >= 4), 16'h1);
        chk("R6 rr share ch7", 16'(cnt[7] >= 4), 16'h1);

        // R8: disabling ch3 stops its grants
        cfg_write(3, 1'b0, 5, 0);
        repeat (2) @(negedge clk);
        cnt[3] = 0;
        repeat (20) begin @(negedge clk); if (ch_gnt[3]) cnt[3]++; end
        chk("R8 disabled ch3 never granted", 16'(cnt[3]), 16'h0);

        // R7: a lone 25% channel is granted once every 5 clocks
        cfg_write(6, 1'b0, 5, 0);
        cfg_write(7, 1'b0, 5, 0);
        cfg_write(3, 1'b1, 5, 3);
        cnt[3] = 0;
        repeat (100) begin @(negedge clk); if (ch_gnt[3]) cnt[3]++; end
        chk("R7 quarter rate 19..21", 16'(cnt[3] >= 19 && cnt[3] <= 21), 16'h1);

        // R7: 25% versus 100% channel competing
        cfg_write(6, 1'b1, 5, 0);
        cnt[3] = 0; cnt[6] = 0;
        repeat (200) begin
            @(negedge clk);
            if (ch_gnt[3]) cnt[3]++;
            if (ch_gnt[6]) cnt[6]++;
        end
        chk("R7 throttled below full", 16'(cnt[3] < cnt[6]), 16'h1);

        // random mix: requests, completions, table writes
        mst_req = 16'h0;
        repeat (3000) begin
            @(negedge clk);
            mst_req = 16'($urandom) & 16'h0E27;
            xfer_done = ($urandom % 3) == 0;
            if (($urandom % 17) == 0) begin
                cfg_we = 1'b1; cfg_addr = 4'($urandom);
                cfg_wdata = {1'($urandom), 4'({$urandom} % 12), 2'($urandom)};
            end else cfg_we = 1'b0;
        end
        cfg_we = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule